// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the clocked control core for the two gate enables of a synchronous buck half-bridge. Its command arrives as two digitised comparator flags taken from a three-level PWM line. One flag means above the upper threshold and the other means below the lower threshold. When neither flag is set, the line sits in its middle window. The block also reads a supply-good flag, an active-low disable and an active-low skip control. From the power stage it reads two sensed flags: one says the low-side gate has discharged, the other says the switch node has fallen.

From these inputs the block drives the high-side and low-side enables with break-before-make ordering. The turn-on dead time is adaptive: each gate waits for the sensed flag of the other side, then waits a short fixed count. If the switch node never reports low, a fallback timeout turns the low side on anyway. A PWM line that stays in the middle window long enough shuts both gates off. Skip mode blanks only the low side. Every input is asynchronous and passes through a synchroniser. All delays are parameters counted in clock cycles.

Top module: `gdrv_seq`

## Requirements
- R1: Whenever the synchronised supply-good flag is low, both gate enables are low on the next clock edge.
- R2: Whenever the synchronised disable input `en_n` is low, both gate enables are low on the next clock edge. Reset leaves the synchroniser holding the disabled value.
- R3: In steady operation with skip inactive, `gate_hs` equals the PWM high level and `gate_ls` equals its inverse.
- R4: While `skip_n` is low, `gate_ls` stays low and `gate_hs` still follows PWM. Raising `skip_n` during a low phase turns the low side back on.
- R5: On a PWM rise, `gate_ls` drops first. `gate_hs` rises DEADON_CYC cycles after the synchronised `gl_low` flag is seen, which is LAT+1+DEADON_CYC edges after the input change.
- R6: On a PWM fall, `gate_hs` drops first. `gate_ls` rises DEADOFF_CYC cycles after the synchronised `sw_low` flag is seen, which is LAT+1+DEADOFF_CYC edges after the input change.
- R7: If `sw_low` stays low after `gate_hs` turns off, `gate_ls` rises exactly TIMEOUT_CYC edges after the high side turned off, and not earlier.
- R8: A synchronised window command keeps both gates in their current state. If it persists for HOLDOFF_CYC consecutive cycles, both gates go low at edge LAT+HOLDOFF_CYC-1. Leaving the window earlier restarts this count.
- R9: On leaving the shut-off state, a low command turns `gate_ls` on at edge LAT. A high command turns `gate_hs` on at edge LAT when `gl_low` is set, and otherwise keeps it off until `gl_low` arrives.
- R10: The level decodes as high when only `pwm_hi` is set, low when only `pwm_lo` is set, and middle window when neither or both flags are set.
- R11: `gate_hs` and `gate_ls` are never both high in the same cycle. Each gate rises only in a cycle after the other was low.
- R12: During and right after reset, both gate enables are low.
- R13: Inputs pass through SYNC_STAGES flip-flops, so LAT = SYNC_STAGES+1. A direct output response appears at clock edge LAT after the input changes and not at edge LAT-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Bias supply good flag, asynchronous |
| en_n | input | 1 | Active-low output disable, asynchronous |
| skip_n | input | 1 | Active-low skip mode (blanks low side), asynchronous |
| pwm_hi | input | 1 | PWM above upper threshold, asynchronous |
| pwm_lo | input | 1 | PWM below lower threshold, asynchronous |
| gl_low | input | 1 | Low-side gate sensed discharged |
| sw_low | input | 1 | Switch node sensed low |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |

## Verification
A wrong sequencer state shows at the ports as a gate that rises one or more edges away from the computed LAT+1+dead count. It can also show as a low side that waits for a switch-node flag that never comes, instead of timing out at exactly TIMEOUT_CYC. A hold-off counter that fails to restart turns the high side off in the middle of a command that briefly dips into the window. A missed shut-off leaves a gate on after LAT+HOLDOFF_CYC-1 edges. An overlap of the two gates is caught in the first cycle it happens.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [1:0] {
        CMD_LOW  = 2'd0,
        CMD_HIGH = 2'd1,
        CMD_MID  = 2'd2
    } pcmd_t;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_LS    = 3'd1,
        ST_WGL   = 3'd2,
        ST_DON   = 3'd3,
        ST_HS    = 3'd4,
        ST_WSW   = 3'd5,
        ST_DOFF  = 3'd6
    } gstate_t;

    typedef struct packed {
        logic ok;
        logic en_n;
        logic skip_n;
        logic hi;
        logic lo;
        logic gl;
        logic sw;
    } gin_t;

    localparam int GIN_W = $bits(gin_t);

    function automatic pcmd_t pwm_decode(input logic hi, input logic lo);
        if (hi && !lo)      return CMD_HIGH;
        else if (lo && !hi) return CMD_LOW;
        else                return CMD_MID;
    endfunction

    function automatic int imax3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gdrv_window.sv
module gdrv_window
    import gdrv_pkg::*;
#(
    parameter int HOLDOFF_CYC = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  hi_s,
    input  logic  lo_s,
    output pcmd_t cmd,
    output logic  expired
);
    localparam int HW = $clog2(HOLDOFF_CYC + 1);
    localparam logic [HW-1:0] HLAST = HW'(HOLDOFF_CYC - 1);

    logic [HW-1:0] hcnt;

    assign cmd     = pwm_decode(hi_s, lo_s);
    assign expired = active && (cmd == CMD_MID) && (hcnt == HLAST);

    // Count consecutive window cycles; any excursion restarts the count.
    always_ff @(posedge clk) begin
        if (rst || !active || cmd != CMD_MID) hcnt <= '0;
        else if (!expired)                     hcnt <= hcnt + 1'b1;
    end
endmodule

// File: rtl/gdrv_phase.sv
module gdrv_phase
    import gdrv_pkg::*;
#(
    parameter int DEADON_CYC  = 2,
    parameter int DEADOFF_CYC = 2,
    parameter int TIMEOUT_CYC = 25
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  pcmd_t cmd,
    input  logic  expired,
    input  logic  skip_act,
    input  logic  gl_s,
    input  logic  sw_s,
    output logic  gate_hs,
    output logic  gate_ls
);
    localparam int CMAX = imax3(DEADON_CYC, DEADOFF_CYC, TIMEOUT_CYC);
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(DEADON_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(DEADOFF_CYC - 1);
    localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);

    gstate_t       state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt = state;
        if (!active || expired) begin
            nxt = ST_OFF;
        end else if (cmd != CMD_MID) begin
            case (state)
                ST_OFF:  nxt = (cmd == CMD_LOW) ? ST_LS : (gl_s ? ST_HS : ST_WGL);
                ST_LS:   if (cmd == CMD_HIGH) nxt = ST_WGL;
                ST_WGL:  if (cmd == CMD_LOW) nxt = ST_LS;
                         else if (gl_s) nxt = ST_DON;
                ST_DON:  if (cmd == CMD_LOW) nxt = ST_LS;
                         else if (cnt == ON_LAST) nxt = ST_HS;
                ST_HS:   if (cmd == CMD_LOW) nxt = ST_WSW;
                ST_WSW:  if (cmd == CMD_HIGH) nxt = ST_HS;
                         else if (sw_s) nxt = ST_DOFF;
                         else if (cnt == TO_LAST) nxt = ST_LS;
                ST_DOFF: if (cmd == CMD_HIGH) nxt = ST_HS;
                         else if (cnt == OFF_LAST) nxt = ST_LS;
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        if (nxt != state)
            cnt_nxt = '0;
        else if (cmd == CMD_MID || !(state inside {ST_DON, ST_WSW, ST_DOFF}))
            cnt_nxt = cnt;
        else
            cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            cnt     <= '0;
            gate_hs <= 1'b0;
            gate_ls <= 1'b0;
        end else begin
            state   <= nxt;
            cnt     <= cnt_nxt;
            gate_hs <= (nxt == ST_HS);
            gate_ls <= (nxt == ST_LS) && !skip_act;
        end
    end
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
    import gdrv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLDOFF_CYC = 16,
    parameter int DEADON_CYC  = 2,
    parameter int DEADOFF_CYC = 2,
    parameter int TIMEOUT_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic en_n,
    input  logic skip_n,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic gl_low,
    input  logic sw_low,
    output logic gate_hs,
    output logic gate_ls
);
    gin_t  raw_in, syn_in;
    pcmd_t cmd;
    logic  expired;
    logic  ok_s, en_n_s, skip_n_s, active;

    assign raw_in = '{ok: supply_ok, en_n: en_n, skip_n: skip_n,
                      hi: pwm_hi, lo: pwm_lo, gl: gl_low, sw: sw_low};

    gdrv_sync #(.W(GIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign ok_s     = syn_in.ok;
    assign en_n_s   = syn_in.en_n;
    assign skip_n_s = syn_in.skip_n;
    assign active   = ok_s && en_n_s;

    gdrv_window #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_window (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .hi_s    (syn_in.hi),
        .lo_s    (syn_in.lo),
        .cmd     (cmd),
        .expired (expired)
    );

    gdrv_phase #(
        .DEADON_CYC  (DEADON_CYC),
        .DEADOFF_CYC (DEADOFF_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .cmd      (cmd),
        .expired  (expired),
        .skip_act (!skip_n_s),
        .gl_s     (syn_in.gl),
        .sw_s     (syn_in.sw),
        .gate_hs  (gate_hs),
        .gate_ls  (gate_ls)
    );
endmodule

// File: rtl/gdrv_seq_chk.sv
module gdrv_seq_chk (
    input logic clk,
    input logic rst,
    input logic ok_s,
    input logic en_n_s,
    input logic skip_n_s,
    input logic gate_hs,
    input logic gate_ls
);
    a_r1_uvlo_off: assert property (@(posedge clk) disable iff (rst)
        !ok_s |=> (!gate_hs && !gate_ls));

    a_r2_disable_off: assert property (@(posedge clk) disable iff (rst)
        !en_n_s |=> (!gate_hs && !gate_ls));

    a_r4_skip_blank: assert property (@(posedge clk) disable iff (rst)
        !skip_n_s |=> !gate_ls);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_hs && gate_ls));

    a_r11_hs_after_ls: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hs) |-> $past(!gate_ls));

    a_r11_ls_after_hs: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_ls) |-> $past(!gate_hs));
endmodule

bind gdrv_seq gdrv_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ok_s     (ok_s),
    .en_n_s   (en_n_s),
    .skip_n_s (skip_n_s),
    .gate_hs  (gate_hs),
    .gate_ls  (gate_ls)
);

// File: tb/test_gdrv_seq.sv
module test_gdrv_seq;
    localparam int SYNC    = 2;
    localparam int HOLD    = 16;
    localparam int DON     = 2;
    localparam int DOFF    = 2;
    localparam int TMO     = 25;
    localparam int LAT     = SYNC + 1;
    localparam int SETTLE  = 40;
    localparam int NVEC    = 12;

    // [8] supply_ok [7] en_n [6] skip_n [5:4] level (0 low, 1 high,
    // 2 no flag, 3 both flags) [3] gl_low [2] sw_low [1] exp hs [0] exp ls
    localparam logic [8:0] VEC [NVEC] = '{
        9'b1_1_1_01_1_1_10,  // R3 high from off
        9'b1_1_1_00_1_1_01,  // R3 R6 low phase
        9'b1_1_0_00_1_1_00,  // R4 skip blanks low side
        9'b1_1_0_01_1_1_10,  // R4 high side still follows
        9'b0_1_0_01_1_1_00,  // R1 supply lost
        9'b1_0_1_00_1_1_00,  // R2 disabled
        9'b1_1_1_00_1_1_01,  // R9 re-enable low
        9'b1_1_1_10_1_1_00,  // R8 R10 window, no flags
        9'b1_1_1_01_0_0_00,  // R9 high waits for gl_low
        9'b1_1_1_01_1_0_10,  // R5 gl_low arrives
        9'b1_1_1_00_1_0_01,  // R7 timeout path
        9'b1_1_1_11_1_0_00   // R10 both flags means window
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, en_n = 1'b0, skip_n = 1'b1;
    logic pwm_hi = 1'b0, pwm_lo = 1'b0, gl_low = 1'b0, sw_low = 1'b0;
    logic gate_hs, gate_ls;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    gdrv_seq #(
        .SYNC_STAGES (SYNC), .HOLDOFF_CYC (HOLD), .DEADON_CYC (DON),
        .DEADOFF_CYC (DOFF), .TIMEOUT_CYC (TMO)
    ) i_gdrv_seq (
        .clk (clk), .rst (rst), .supply_ok (supply_ok), .en_n (en_n),
        .skip_n (skip_n), .pwm_hi (pwm_hi), .pwm_lo (pwm_lo),
        .gl_low (gl_low), .sw_low (sw_low),
        .gate_hs (gate_hs), .gate_ls (gate_ls)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic lvl(input logic [1:0] l);
        pwm_hi = (l == 2'd1) || (l == 2'd3);
        pwm_lo = (l == 2'd0) || (l == 2'd3);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R11: overlap monitor, every cycle
    always @(negedge clk) begin
        if (!rst && !done && gate_hs && gate_ls) begin
            n_fail++;
            $display("FAIL R11: got hs=1 ls=1 expected not both at %0t", $time);
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R12 hs in reset", gate_hs, 1'b0);
        chk("R12 ls in reset", gate_ls, 1'b0);
        rst = 1'b0;
        supply_ok = 1'b1; en_n = 1'b1; gl_low = 1'b1; sw_low = 1'b1;
        cyc(1);
        chk("R12 hs after reset", gate_hs, 1'b0);
        chk("R12 ls after reset", gate_ls, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            supply_ok = VEC[v][8]; en_n = VEC[v][7]; skip_n = VEC[v][6];
            lvl(VEC[v][5:4]); gl_low = VEC[v][3]; sw_low = VEC[v][2];
            cyc(SETTLE);
            chk($sformatf("R3 vector %0d hs", v), gate_hs, VEC[v][1]);
            chk($sformatf("R3 vector %0d ls", v), gate_ls, VEC[v][0]);
        end

        // R5 / R13: rising edge timing
        supply_ok = 1; en_n = 1; skip_n = 1; gl_low = 1; sw_low = 1; lvl(0);
        cyc(SETTLE);
        lvl(1);
        cyc(LAT - 1); chk("R13 ls before latency", gate_ls, 1'b1);
        cyc(1);       chk("R5 ls off first", gate_ls, 1'b0);
        chk("R5 hs still off", gate_hs, 1'b0);
        cyc(DON);     chk("R5 hs before dead-on", gate_hs, 1'b0);
        cyc(1);       chk("R5 hs after dead-on", gate_hs, 1'b1);

        // R6: falling edge with switch node flag present
        cyc(SETTLE);
        lvl(0);
        cyc(LAT);     chk("R6 hs off first", gate_hs, 1'b0);
        chk("R6 ls still off", gate_ls, 1'b0);
        cyc(DOFF);    chk("R6 ls before dead-off", gate_ls, 1'b0);
        cyc(1);       chk("R6 ls after dead-off", gate_ls, 1'b1);

        // R7: timeout without switch node flag
        lvl(1); cyc(SETTLE); sw_low = 0; cyc(SETTLE);
        lvl(0);
        cyc(LAT + TMO - 1); chk("R7 ls before timeout", gate_ls, 1'b0);
        chk("R7 hs off", gate_hs, 1'b0);
        cyc(1);             chk("R7 ls at timeout", gate_ls, 1'b1);
        sw_low = 1;

        // R8: hold-off boundary
        lvl(1); cyc(SETTLE);
        lvl(2);
        cyc(LAT + HOLD - 2); chk("R8 hs held in window", gate_hs, 1'b1);
        cyc(1);              chk("R8 hs off at hold-off", gate_hs, 1'b0);
        chk("R8 ls off at hold-off", gate_ls, 1'b0);

        // R8: restart of the hold-off count
        lvl(1); cyc(SETTLE);
        lvl(2); cyc(10); lvl(1); cyc(5);
        lvl(2); cyc(10);
        chk("R8 count restarted", gate_hs, 1'b1);
        lvl(1); cyc(SETTLE);

        // R9: exit from shut-off to low and to high
        lvl(2); cyc(SETTLE);
        lvl(0);
        cyc(LAT - 1); chk("R9 ls before exit", gate_ls, 1'b0);
        cyc(1);       chk("R9 ls on exit low", gate_ls, 1'b1);
        lvl(2); cyc(SETTLE);
        lvl(1);
        cyc(LAT);     chk("R9 hs on exit high", gate_hs, 1'b1);

        // R4: skip toggled during a low phase
        lvl(0); cyc(SETTLE);
        skip_n = 0;
        cyc(LAT);     chk("R4 ls blanked", gate_ls, 1'b0);
        skip_n = 1;
        cyc(LAT);     chk("R4 ls restored", gate_ls, 1'b1);

        // R1 / R2: immediate shut-off timing
        en_n = 0;
        cyc(LAT);     chk("R2 ls off on disable", gate_ls, 1'b0);
        en_n = 1; cyc(SETTLE);
        lvl(1); cyc(SETTLE);
        supply_ok = 0;
        cyc(LAT);     chk("R1 hs off on supply loss", gate_hs, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule